// File: doc/BRIEF.md
# Dual-Channel Serial DAC Transmitter

This block feeds a two-channel 12-bit serial DAC from a system clock domain. It divides the system clock by two to make the serial clock and frames each transfer with an active-low frame strobe. It shifts one 16-bit word per channel, most significant bit first, on two data lines that run in lockstep. Both words share the strobe and the serial clock.

A sample pair is written by holding the two values on the sample inputs and pulsing the update input for one system clock. The block samples the values at the moment the frame loads, which is the serial-clock rising edge that starts the transfer. An update that arrives while a frame is being sent is remembered. Its frame then follows after one idle serial period, during which the strobe is deasserted, as a DAC needs between frames. While the divider enable is low the serial clock stops and no frame can start. A pending update is kept until the enable returns.

Top module: `dac_dual_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `sclk_o` is 0, `sync_n_o` is 1, `sdata_o` is 2'b00 and `busy_o` is 0.
- R2: While `div_en` is 1, `sclk_o` inverts on every system clock edge, so one serial period is two system clocks. While `div_en` is 0, `sclk_o` is held at 0.
- R3: An update while idle makes `sync_n_o` fall to 0 and `busy_o` rise to 1 on a rising edge of `sclk_o`. This happens no more than three system clocks after the update pulse.
- R4: Each channel word is 16 bits. Bits 15:14 are 2'b00, bits 13:12 are the mode field fixed at 2'b00 (normal operation), and bits 11:0 are the sample. Bit 15 goes out first. The data lines change only on rising edges of `sclk_o`, so each bit is held for one full serial period.
- R5: The channel 0 word appears on `sdata_o[0]` and the channel 1 word on `sdata_o[1]`. The two lines carry their bits during the same serial periods.
- R6: A frame lasts exactly 16 serial periods. On the 17th rising edge, `sync_n_o` returns to 1, `busy_o` drops to 0 and both data lines go to 0. The data lines are 0 whenever `sync_n_o` is 1.
- R7: An update during a frame is latched. The next frame starts on the second `sclk_o` rising edge after the current frame ends, which leaves exactly one idle serial period. Several updates during one frame produce only one further frame.
- R8: The sample inputs are captured when the frame loads. Changes to them during a frame do not alter that frame's words.
- R9: With no update, the block stays idle: `sync_n_o` is 1, `busy_o` is 0 and `sdata_o` is 2'b00.
- R10: An update given while `div_en` is 0 starts no frame while the enable stays low. Its frame is sent once `div_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | Enables the serial clock divider |
| update | input | 1 | One-cycle request to send the current sample pair |
| ch0_sample | input | 12 | Channel 0 sample |
| ch1_sample | input | 12 | Channel 1 sample |
| sclk_o | output | 1 | Serial clock, system clock divided by two |
| sync_n_o | output | 1 | Active-low frame strobe |
| sdata_o | output | 2 | Serial data, bit 0 for channel 0 and bit 1 for channel 1 |
| busy_o | output | 1 | High from frame load until the 16th bit has been sent |

## Verification
The bench targets a back-to-back request made during a frame, while the sample inputs are also changed after the load. A design that resamples late would send the new values in the first frame. A design with no gap or no latch would either merge the two frames under one strobe or drop the second frame entirely. Repeated update pulses within one frame are also sent. A design that counts requests would emit an extra frame, and the scoreboard reports that as an unexpected frame. The divider enable is dropped while a request is pending. A design that ignores the enable would start a frame with no serial clock running, and one that drops the request would never send it. A frame of 15 or 17 bits is caught by the monitor's per-frame bit count.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    parameter int DATA_W  = 12;
    parameter int MODE_W  = 2;
    parameter int PAD_W   = 2;
    parameter int FRAME_W = PAD_W + MODE_W + DATA_W;
    parameter int CNT_W   = $clog2(FRAME_W);
    parameter int NUM_CH  = 2;

    localparam logic [MODE_W-1:0] MODE_NORMAL = '0;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

    // Per-lane command issued by the controller once per serial rising edge
    typedef struct packed {
        logic load;
        logic shift;
        logic clear;
    } lane_cmd_t;

    function automatic frame_t build_frame(input logic [DATA_W-1:0] sample,
                                           input logic [MODE_W-1:0] mode);
        return {{PAD_W{1'b0}}, mode, sample};
    endfunction

endpackage

// File: rtl/dac_sclk_div.sv
module dac_sclk_div (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic rise_pls
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst)     sclk_q <= 1'b0;
        else if (en) sclk_q <= ~sclk_q;
        else         sclk_q <= 1'b0;
    end

    // Asserted in the system cycle whose closing edge raises the serial clock
    assign rise_pls = en & ~sclk_q;
    assign sclk     = sclk_q;

endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
    import dac_tx_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_pls,
    input  logic      update,
    output lane_cmd_t cmd,
    output logic      active
);
    localparam int              CW   = $clog2(FW);
    localparam logic [CW-1:0]   LAST = CW'(FW - 1);

    tx_state_e      state;
    logic [CW-1:0]  cnt;
    logic           pending;

    always_comb begin
        cmd       = '0;
        cmd.load  = rise_pls && (state == ST_IDLE) && pending;
        cmd.shift = rise_pls && (state == ST_SHIFT) && (cnt != LAST);
        cmd.clear = rise_pls && (state == ST_SHIFT) && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            pending <= (pending & ~cmd.load) | update;
            if (cmd.load) begin
                state <= ST_SHIFT;
                cnt   <= '0;
            end else if (cmd.shift) begin
                cnt   <= cnt + CW'(1);
            end else if (cmd.clear) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end
        end
    end

    assign active = (state == ST_SHIFT);

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SHIFT && state == ST_IDLE) |-> ($past(cnt) == LAST)); // R6

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (update && state == ST_SHIFT) |=> pending); // R7

endmodule

// File: rtl/dac_lane_shifter.sv
module dac_lane_shifter
    import dac_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_cmd_t         cmd,
    input  logic [DATA_W-1:0] sample,
    output logic              bit_o
);
    frame_t sh;

    always_ff @(posedge clk) begin
        if (rst)            sh <= '0;
        else if (cmd.load)  sh <= build_frame(sample, MODE_NORMAL);
        else if (cmd.shift) sh <= {sh[FRAME_W-2:0], 1'b0};
        else if (cmd.clear) sh <= '0;
    end

    assign bit_o = sh[FRAME_W-1];

endmodule

// File: rtl/dac_dual_tx.sv
module dac_dual_tx
    import dac_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              div_en,
    input  logic              update,
    input  logic [DATA_W-1:0] ch0_sample,
    input  logic [DATA_W-1:0] ch1_sample,
    output logic              sclk_o,
    output logic              sync_n_o,
    output logic [NUM_CH-1:0] sdata_o,
    output logic              busy_o
);
    logic      rise_pls;
    logic      active;
    lane_cmd_t cmd;
    logic [DATA_W-1:0] samples [NUM_CH];

    assign samples[0] = ch0_sample;
    assign samples[1] = ch1_sample;

    dac_sclk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (div_en),
        .sclk     (sclk_o),
        .rise_pls (rise_pls)
    );

    dac_frame_ctrl #(.FW(FRAME_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rise_pls (rise_pls),
        .update   (update),
        .cmd      (cmd),
        .active   (active)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        dac_lane_shifter u_lane (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .sample (samples[g]),
            .bit_o  (sdata_o[g])
        );
    end

    assign sync_n_o = ~active;
    assign busy_o   = active;

    AST_SCLK_HALT: assert property (@(posedge clk) disable iff (rst)
        !div_en |=> !sclk_o); // R2

    AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_n_o) |-> $rose(sclk_o)); // R3

    AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> $rose(sclk_o)); // R4

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        sync_n_o |-> (sdata_o == '0)); // R6

endmodule

// File: tb/dac_dual_tx_tb_top.sv
module dac_dual_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_en = 1'b1;
    logic        update = 1'b0;
    logic [11:0] ch0_sample = '0;
    logic [11:0] ch1_sample = '0;
    logic        sclk_o, sync_n_o, busy_o;
    logic [1:0]  sdata_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    dac_dual_tx dut_i (
        .clk(clk), .rst(rst), .div_en(div_en), .update(update),
        .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
        .sclk_o(sclk_o), .sync_n_o(sync_n_o), .sdata_o(sdata_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: set samples, record expected word pair, pulse update
    task automatic queue_frame(input logic [11:0] v0, input logic [11:0] v1);
        @(negedge clk);
        ch0_sample = v0;
        ch1_sample = v1;
        update = 1'b1;
        exp_q.push_back({4'b0000, v1, 4'b0000, v0});
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !busy_o) break;
        end
        repeat (6) @(negedge clk);
    endtask

    // Monitor: gathers bits on serial rising edges and compares with the scoreboard
    logic        prev_sclk = 1'b0;
    int          nbits = 0;
    int          idle_rises = 0;
    int          last_gap = -1;
    logic [15:0] sh0, sh1;
    always @(negedge clk) begin
        if (rst) begin
            prev_sclk <= 1'b0;
        end else begin
            if (sclk_o && !prev_sclk) begin
                if (!sync_n_o) begin
                    if (nbits == 0) last_gap = idle_rises;
                    sh0 = {sh0[14:0], sdata_o[0]};
                    sh1 = {sh1[14:0], sdata_o[1]};
                    nbits++;
                    check(busy_o == 1'b1, "R6 busy during frame", {31'd0, busy_o}, 32'd1);
                    if (nbits == 16) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R7 unexpected extra frame", {sh1, sh0}, 32'd0);
                        end else begin
                            logic [31:0] e;
                            e = exp_q.pop_front();
                            check({sh1, sh0} == e, "R4 R5 R8 frame words", {sh1, sh0}, e);
                        end
                    end
                    if (nbits == 17)
                        check(1'b0, "R6 frame longer than 16 bits", 32'd17, 32'd16);
                end else begin
                    if (nbits != 0) begin
                        check(nbits == 16, "R6 frame bit count", nbits, 32'd16);
                        check(!busy_o && sdata_o == 2'b00, "R6 idle after frame",
                              {29'd0, busy_o, sdata_o}, 32'd0);
                        nbits = 0;
                        idle_rises = 1;
                    end else begin
                        idle_rises++;
                    end
                end
            end
            prev_sclk <= sclk_o;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int toggles;
        int lat;
        logic ps;
        repeat (4) @(negedge clk);
        check(sclk_o == 0 && sync_n_o == 1 && sdata_o == 0 && busy_o == 0, "R1 reset state",
              {28'd0, sclk_o, sync_n_o, sdata_o[0], busy_o}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(sync_n_o == 1 && busy_o == 0 && sdata_o == 0, "R1 first cycle after reset",
              {29'd0, sync_n_o, busy_o, sdata_o[0]}, 32'h4);

        // R2: divider toggles every cycle
        toggles = 0;
        ps = sclk_o;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sclk_o != ps) toggles++;
            ps = sclk_o;
        end
        check(toggles == 8, "R2 sclk toggles each cycle", toggles, 32'd8);

        // R9: idle with no request
        repeat (40) @(negedge clk);
        check(sync_n_o && !busy_o && sdata_o == 0, "R9 idle without update",
              {29'd0, sync_n_o, busy_o, sdata_o[0]}, 32'h4);

        // R3: start latency and alignment
        @(negedge clk);
        ch0_sample = 12'hA5C;
        ch1_sample = 12'h3F1;
        update = 1'b1;
        exp_q.push_back({4'b0000, 12'h3F1, 4'b0000, 12'hA5C});
        lat = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            update = 1'b0;
            lat++;
            if (busy_o) break;
        end
        check(busy_o && lat <= 3, "R3 start latency", lat, 32'd3);
        check(sclk_o == 1'b1 && sync_n_o == 1'b0, "R3 start on sclk rise",
              {30'd0, sclk_o, sync_n_o}, 32'h2);
        wait_drain();

        // R4/R5: distinct patterns
        queue_frame(12'hFFF, 12'h000);
        wait_drain();
        queue_frame(12'h001, 12'h800);
        wait_drain();

        // R7/R8: new values and two updates during a frame
        queue_frame(12'h123, 12'h456);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy_o) break;
        end
        repeat (6) @(negedge clk);
        ch0_sample = 12'hBEE;
        ch1_sample = 12'h0DD;
        exp_q.push_back({4'b0000, 12'h0DD, 4'b0000, 12'hBEE});
        pulse_update();
        repeat (4) @(negedge clk);
        pulse_update();
        wait_drain();
        check(last_gap == 1, "R7 one idle serial period between frames", last_gap, 32'd1);
        repeat (80) @(negedge clk);
        check(exp_q.size() == 0 && !busy_o, "R7 no extra frame", exp_q.size(), 32'd0);

        // R10: request while divider disabled
        @(negedge clk);
        div_en = 1'b0;
        repeat (3) @(negedge clk);
        queue_frame(12'h5A5, 12'hC3C);
        repeat (40) @(negedge clk);
        check(!busy_o && sync_n_o && sclk_o == 0, "R10 R2 no frame while disabled",
              {29'd0, busy_o, sync_n_o, sclk_o}, 32'h2);
        div_en = 1'b1;
        wait_drain();
        check(exp_q.size() == 0, "R10 pending frame sent after enable", exp_q.size(), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule